// File: doc/BRIEF.md
# Pointer-Addressed Temperature-Sensor Register Bank

This block is the register side of a two-wire temperature-sensor slave. An external byte engine handles the bus bit timing. It hands this block decoded events: a pointer byte written, a data byte written, a data byte requested, and the end of a transaction. An 8-bit pointer selects one of 256 16-bit locations. The locations are:

- a fixed capability word;
- configuration;
- three alarm trip limits (upper, lower, critical);
- a live temperature value loaded from a sensor port;
- fixed manufacturer and device identifiers;
- a write-only SMBus control word;
- reserved space that always reads as zero.

The writable words are driven out as ports so that the conversion and alarm logic can use them.

A read returns the selected word as the high byte and then the low byte. Further requests in the same transaction repeat that order on the same word. A write needs two data bytes after the pointer byte, high byte first. The target word changes only when the second byte arrives. A transaction that carries only one data byte sets the pointer and changes nothing else.

After a reset the block stays in its power-on state for as long as the bus clock line is low. While in that state it ignores every bus event.

Top module: `sensor_regbank`

## Requirements
- R1: After power-on, the locations read as follows:
  - pointer 00h reads 0017h;
  - pointers 01h to 04h read 0000h;
  - pointer 06h reads 1131h;
  - pointer 07h reads A200h;
  - pointer 05h reads 0000h until a sensor sample is loaded.
- R2: The capability word at pointer 00h has these fields:
  - bits 15:6 read as zero;
  - bit 5 reads as zero;
  - bits 4:3 read as binary 10, meaning 0.125 °C resolution;
  - bits 2, 1 and 0 each read as 1.
- R3: Read requests return the high byte (bits 15:8) first and then the low byte (bits 7:0) of the selected word. The pointer does not advance. Later requests in the same transaction alternate high and low bytes of the same word.
- R4: Each accepted `rd_req` produces `rd_valid` high for exactly one cycle, in the cycle after the request, with the byte on `rd_data`. No other cycle has `rd_valid` high.
- R5: Configuration (01h), upper trip (02h), lower trip (03h) and critical trip (04h) are writable. The first data byte after the pointer is bits 15:8 and the second is bits 7:0. The word and its output port change at the clock edge that takes the second byte.
- R6: A transaction with a pointer byte and a single data byte followed by `txn_end` changes no register. It leaves the pointer set, so a later read without a new pointer byte reads that location.
- R7: Writes to the capability (00h), temperature (05h), manufacturer (06h) and device (07h) locations are accepted and discarded.
- R8: The SMBus word at 22h is write-only. Its written value appears on `smbus_q`, and reads at 22h return 0000h.
- R9: Writes to reserved locations (08h–21h and 23h–FFh) are discarded, and those locations read 0000h.
- R10: A `temp_load` pulse copies `temp_in` into the temperature word. Reads at 05h return the last loaded value.
- R11: Power-on hold starts when `rst` is high. It lasts until a cycle in which `scl_in` is high. During the hold:
  - all writable words return to their defaults;
  - bus writes are ignored;
  - read requests produce no `rd_valid`.
- R12: A pointer byte or `txn_end` restarts both byte orders. The next read returns a high byte, and the next data byte is taken as bits 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| scl_in | input | 1 | Level of the bus clock line; low extends the power-on hold |
| ptr_wr_valid | input | 1 | Pointer byte received |
| ptr_wr_data | input | 8 | Pointer value |
| data_wr_valid | input | 1 | Data byte received for write |
| data_wr_data | input | 8 | Written data byte |
| rd_req | input | 1 | Engine requests the next read byte |
| txn_end | input | 1 | Stop condition seen; ends the transaction |
| temp_load | input | 1 | Sensor sample strobe |
| temp_in | input | 16 | Sensor sample value |
| rd_valid | output | 1 | `rd_data` holds a requested byte |
| rd_data | output | 8 | Read byte |
| cfg_q | output | 16 | Configuration word |
| trip_hi_q | output | 16 | Upper alarm trip word |
| trip_lo_q | output | 16 | Lower alarm trip word |
| trip_crit_q | output | 16 | Critical alarm trip word |
| smbus_q | output | 16 | SMBus control word |

## Verification
Reads are tried at every fixed, writable, write-only and reserved location. Comparing them with the values written separates correct address decoding from decoding that lets writes leak into the wrong location. Transactions with two data bytes, with one data byte, and with two bytes aimed at read-only or reserved pointers show apart proper commit timing, pointer-only transactions and discarded writes. Long read runs, and read runs cut short by a new pointer byte, test the high/low alternation and its restart. Bus events issued while the clock line is held low after reset confirm that the power-on hold blocks both writes and reads.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam logic [7:0] PTR_CAP   = 8'h00;
  localparam logic [7:0] PTR_CFG   = 8'h01;
  localparam logic [7:0] PTR_TRIP0 = 8'h02;
  localparam logic [7:0] PTR_TEMP  = 8'h05;
  localparam logic [7:0] PTR_MFR   = 8'h06;
  localparam logic [7:0] PTR_DEV   = 8'h07;
  localparam logic [7:0] PTR_SMB   = 8'h22;

  localparam int TRIP_N = 3;

  // capability: [15:6]=0, [5]=0, [4:3]=2'b10, [2:0]=3'b111
  localparam logic [15:0] CAP_WORD = {10'd0, 1'b0, 2'b10, 1'b1, 1'b1, 1'b1};
  localparam logic [15:0] MFR_WORD = 16'h1131;
  localparam logic [15:0] DEV_WORD = 16'hA200;
  localparam logic [15:0] RW_DFLT  = 16'h0000;
endpackage

// File: rtl/regbank_por.sv
module regbank_por (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  output logic hold,
  output logic rst_eff
);
  logic hold_q;

  always_ff @(posedge clk) begin
    if (rst)         hold_q <= 1'b1;
    else if (scl_in) hold_q <= 1'b0;
  end

  assign hold    = hold_q;
  assign rst_eff = rst | hold_q;
endmodule

// File: rtl/regbank_seq.sv
module regbank_seq #(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_eff,
  input  logic                ptr_wr_valid,
  input  logic [ADDR_W-1:0]   ptr_wr_data,
  input  logic                data_wr_valid,
  input  logic [BYTE_W-1:0]   data_wr_data,
  input  logic                rd_req,
  input  logic                txn_end,
  output logic [ADDR_W-1:0]   ptr,
  output logic                wr_commit,
  output logic [2*BYTE_W-1:0] wr_word,
  output logic                rd_fire,
  output logic                rd_lo
);
  logic [ADDR_W-1:0] ptr_q;
  logic [BYTE_W-1:0] msb_q;
  logic              wr_lo_q;
  logic              rd_lo_q;
  logic              wr_take;

  assign wr_take   = data_wr_valid && !ptr_wr_valid && !rst_eff;
  assign wr_commit = wr_take && wr_lo_q;
  assign wr_word   = {msb_q, data_wr_data};
  assign rd_fire   = rd_req && !rst_eff;
  assign rd_lo     = rd_lo_q;
  assign ptr       = ptr_q;

  always_ff @(posedge clk) begin
    if (rst_eff) begin
      ptr_q   <= '0;
      msb_q   <= '0;
      wr_lo_q <= 1'b0;
      rd_lo_q <= 1'b0;
    end else begin
      if (ptr_wr_valid || txn_end) begin
        wr_lo_q <= 1'b0;
        rd_lo_q <= 1'b0;
        if (ptr_wr_valid) ptr_q <= ptr_wr_data;
      end else begin
        if (wr_take) begin
          wr_lo_q <= !wr_lo_q;
          if (!wr_lo_q) msb_q <= data_wr_data;
        end
        if (rd_fire) rd_lo_q <= !rd_lo_q;
      end
    end
  end
endmodule

// File: rtl/regbank_store.sv
module regbank_store
  import regbank_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_eff,
  input  logic [ADDR_W-1:0] ptr,
  input  logic              wr_commit,
  input  logic [DATA_W-1:0] wr_word,
  input  logic              temp_load,
  input  logic [DATA_W-1:0] temp_in,
  output logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] cfg_q,
  output logic [DATA_W-1:0] trip_q [TRIP_N],
  output logic [DATA_W-1:0] smbus_q
);
  logic [DATA_W-1:0] temp_q;

  always_ff @(posedge clk) begin
    if (rst_eff) cfg_q <= DATA_W'(RW_DFLT);
    else if (wr_commit && ptr == ADDR_W'(PTR_CFG)) cfg_q <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rst_eff) smbus_q <= DATA_W'(RW_DFLT);
    else if (wr_commit && ptr == ADDR_W'(PTR_SMB)) smbus_q <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rst_eff) temp_q <= '0;
    else if (temp_load) temp_q <= temp_in;
  end

  for (genvar i = 0; i < TRIP_N; i++) begin : g_trip
    localparam logic [ADDR_W-1:0] MY_PTR = ADDR_W'(PTR_TRIP0) + ADDR_W'(i);
    always_ff @(posedge clk) begin
      if (rst_eff) trip_q[i] <= DATA_W'(RW_DFLT);
      else if (wr_commit && ptr == MY_PTR) trip_q[i] <= wr_word;
    end
  end

  always_comb begin
    rd_word = '0;
    if (ptr == ADDR_W'(PTR_CAP))                   rd_word = DATA_W'(CAP_WORD);
    else if (ptr == ADDR_W'(PTR_CFG))              rd_word = cfg_q;
    else if (ptr == ADDR_W'(PTR_TRIP0))            rd_word = trip_q[0];
    else if (ptr == ADDR_W'(PTR_TRIP0) + ADDR_W'(1)) rd_word = trip_q[1];
    else if (ptr == ADDR_W'(PTR_TRIP0) + ADDR_W'(2)) rd_word = trip_q[2];
    else if (ptr == ADDR_W'(PTR_TEMP))             rd_word = temp_q;
    else if (ptr == ADDR_W'(PTR_MFR))              rd_word = DATA_W'(MFR_WORD);
    else if (ptr == ADDR_W'(PTR_DEV))              rd_word = DATA_W'(DEV_WORD);
  end
endmodule

// File: rtl/sensor_regbank.sv
module sensor_regbank
  import regbank_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 8,
  localparam int DATA_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              ptr_wr_valid,
  input  logic [ADDR_W-1:0] ptr_wr_data,
  input  logic              data_wr_valid,
  input  logic [BYTE_W-1:0] data_wr_data,
  input  logic              rd_req,
  input  logic              txn_end,
  input  logic              temp_load,
  input  logic [DATA_W-1:0] temp_in,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] rd_data,
  output logic [DATA_W-1:0] cfg_q,
  output logic [DATA_W-1:0] trip_hi_q,
  output logic [DATA_W-1:0] trip_lo_q,
  output logic [DATA_W-1:0] trip_crit_q,
  output logic [DATA_W-1:0] smbus_q
);
  logic              hold;
  logic              rst_eff;
  logic [ADDR_W-1:0] ptr;
  logic              wr_commit;
  logic [DATA_W-1:0] wr_word;
  logic              rd_fire;
  logic              rd_lo;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] trip_q [TRIP_N];

  regbank_por u_por (
    .clk(clk), .rst(rst), .scl_in(scl_in), .hold(hold), .rst_eff(rst_eff)
  );

  regbank_seq #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_seq (
    .clk(clk), .rst_eff(rst_eff),
    .ptr_wr_valid(ptr_wr_valid), .ptr_wr_data(ptr_wr_data),
    .data_wr_valid(data_wr_valid), .data_wr_data(data_wr_data),
    .rd_req(rd_req), .txn_end(txn_end),
    .ptr(ptr), .wr_commit(wr_commit), .wr_word(wr_word),
    .rd_fire(rd_fire), .rd_lo(rd_lo)
  );

  regbank_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_eff(rst_eff), .ptr(ptr),
    .wr_commit(wr_commit), .wr_word(wr_word),
    .temp_load(temp_load), .temp_in(temp_in),
    .rd_word(rd_word), .cfg_q(cfg_q), .trip_q(trip_q), .smbus_q(smbus_q)
  );

  assign trip_hi_q   = trip_q[0];
  assign trip_lo_q   = trip_q[1];
  assign trip_crit_q = trip_q[2];

  always_ff @(posedge clk) begin
    if (rst_eff) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) rd_data <= rd_lo ? rd_word[BYTE_W-1:0] : rd_word[DATA_W-1:BYTE_W];
    end
  end
endmodule

// File: rtl/regbank_chk.sv
module regbank_chk #(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_in,
  input logic              hold,
  input logic              rd_req,
  input logic              rd_valid,
  input logic [BYTE_W-1:0] rd_data,
  input logic              data_wr_valid,
  input logic [ADDR_W-1:0] ptr,
  input logic [2*BYTE_W-1:0] cfg_q,
  input logic [2*BYTE_W-1:0] smbus_q
);
  // R11
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    hold && !scl_in |=> hold);

  // R11
  hold_dflt_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> (cfg_q == '0 && smbus_q == '0));

  // R4
  rd_resp_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req && !hold |=> rd_valid);

  // R4
  rd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_req && !hold) |=> !rd_valid);

  // R5
  cfg_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !data_wr_valid && !hold |=> $stable(cfg_q));

  // R8
  smb_rdzero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid && $past(ptr) == ADDR_W'(8'h22) |-> rd_data == '0);
endmodule

bind sensor_regbank regbank_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .scl_in(scl_in), .hold(hold), .rd_req(rd_req),
  .rd_valid(rd_valid), .rd_data(rd_data), .data_wr_valid(data_wr_valid),
  .ptr(ptr), .cfg_q(cfg_q), .smbus_q(smbus_q)
);

// File: tb/sensor_regbank_tb.sv
module sensor_regbank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_in = 1'b0;
  logic        ptr_wr_valid = 1'b0;
  logic [7:0]  ptr_wr_data = '0;
  logic        data_wr_valid = 1'b0;
  logic [7:0]  data_wr_data = '0;
  logic        rd_req = 1'b0;
  logic        txn_end = 1'b0;
  logic        temp_load = 1'b0;
  logic [15:0] temp_in = '0;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic [15:0] cfg_q, trip_hi_q, trip_lo_q, trip_crit_q, smbus_q;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #4 clk = ~clk;

  sensor_regbank u_dut (
    .clk(clk), .rst(rst), .scl_in(scl_in),
    .ptr_wr_valid(ptr_wr_valid), .ptr_wr_data(ptr_wr_data),
    .data_wr_valid(data_wr_valid), .data_wr_data(data_wr_data),
    .rd_req(rd_req), .txn_end(txn_end),
    .temp_load(temp_load), .temp_in(temp_in),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .cfg_q(cfg_q), .trip_hi_q(trip_hi_q), .trip_lo_q(trip_lo_q),
    .trip_crit_q(trip_crit_q), .smbus_q(smbus_q)
  );

  task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read bytes as the design produces them
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4: actual=unexpected byte %h expected=no rd_valid", rd_data);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s: actual=%h expected=%h", t, rd_data, e);
        end
      end
    end
  end

  task automatic set_ptr(input logic [7:0] p);
    @(negedge clk); ptr_wr_valid = 1'b1; ptr_wr_data = p;
    @(negedge clk); ptr_wr_valid = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] b);
    @(negedge clk); data_wr_valid = 1'b1; data_wr_data = b;
    @(negedge clk); data_wr_valid = 1'b0;
  endtask

  task automatic end_txn();
    @(negedge clk); txn_end = 1'b1;
    @(negedge clk); txn_end = 1'b0;
  endtask

  task automatic rd_byte(input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
  endtask

  task automatic write_reg(input logic [7:0] p, input logic [15:0] w);
    set_ptr(p); wr_byte(w[15:8]); wr_byte(w[7:0]); end_txn();
  endtask

  task automatic read_reg(input logic [7:0] p, input logic [15:0] e, input string tag);
    set_ptr(p); rd_byte(e[15:8], tag); rd_byte(e[7:0], tag); end_txn();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R11: clock line still low, events must be ignored
    repeat (3) @(negedge clk);
    set_ptr(8'h01); wr_byte(8'h12); wr_byte(8'h34); end_txn();
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    check16("R11 rd_valid during hold", {15'd0, rd_valid}, 16'h0000);
    check16("R11 cfg during hold", cfg_q, 16'h0000);
    repeat (10) @(negedge clk);
    scl_in = 1'b1;
    repeat (2) @(negedge clk);

    // R1/R2 defaults
    read_reg(8'h00, 16'h0017, "R2 capability");
    read_reg(8'h01, 16'h0000, "R1 cfg default / R11");
    read_reg(8'h02, 16'h0000, "R1 trip hi default");
    read_reg(8'h04, 16'h0000, "R1 trip crit default");
    read_reg(8'h05, 16'h0000, "R1 temp default");
    read_reg(8'h06, 16'h1131, "R1 manufacturer");
    read_reg(8'h07, 16'hA200, "R1 device");
    check16("R1 smbus port default", smbus_q, 16'h0000);

    // R5 writable words
    write_reg(8'h01, 16'h0102);
    check16("R5 cfg port", cfg_q, 16'h0102);
    write_reg(8'h02, 16'h5A3C);
    write_reg(8'h03, 16'hC3A5);
    write_reg(8'h04, 16'h7E81);
    check16("R5 trip hi port", trip_hi_q, 16'h5A3C);
    check16("R5 trip lo port", trip_lo_q, 16'hC3A5);
    check16("R5 trip crit port", trip_crit_q, 16'h7E81);
    read_reg(8'h01, 16'h0102, "R5 cfg read");
    read_reg(8'h03, 16'hC3A5, "R5 trip lo read");
    // R5: port unchanged after first byte only
    set_ptr(8'h01); wr_byte(8'hEE);
    check16("R5 cfg after first byte", cfg_q, 16'h0102);
    wr_byte(8'h11);
    check16("R5 cfg after second byte", cfg_q, 16'hEE11);
    end_txn();

    // R8 write-only smbus
    write_reg(8'h22, 16'hBEEF);
    check16("R8 smbus port", smbus_q, 16'hBEEF);
    read_reg(8'h22, 16'h0000, "R8 smbus reads zero");

    // R7 read-only writes discarded
    write_reg(8'h00, 16'hFFFF);
    write_reg(8'h06, 16'h0000);
    write_reg(8'h07, 16'h1234);
    write_reg(8'h05, 16'h9999);
    read_reg(8'h00, 16'h0017, "R7 capability kept");
    read_reg(8'h06, 16'h1131, "R7 manufacturer kept");
    read_reg(8'h07, 16'hA200, "R7 device kept");
    read_reg(8'h05, 16'h0000, "R7 temp write ignored");

    // R9 reserved
    write_reg(8'h08, 16'hAAAA);
    write_reg(8'h30, 16'h5555);
    read_reg(8'h08, 16'h0000, "R9 reserved 08");
    read_reg(8'h30, 16'h0000, "R9 reserved 30");
    read_reg(8'hFF, 16'h0000, "R9 reserved FF");
    check16("R9 cfg untouched", cfg_q, 16'hEE11);

    // R6 one data byte only sets the pointer
    set_ptr(8'h02); wr_byte(8'h00); end_txn();
    check16("R6 trip hi unchanged", trip_hi_q, 16'h5A3C);
    rd_byte(8'h5A, "R6 pointer kept"); rd_byte(8'h3C, "R6 pointer kept"); end_txn();
    // R12: after txn_end the next data byte is high byte again
    set_ptr(8'h04); wr_byte(8'h42); end_txn();
    set_ptr(8'h04); wr_byte(8'h10); wr_byte(8'h20); end_txn();
    check16("R12 write phase restart", trip_crit_q, 16'h1020);

    // R10 temperature from sensor port
    @(negedge clk); temp_in = 16'h0C95; temp_load = 1'b1;
    @(negedge clk); temp_load = 1'b0; temp_in = 16'hFFFF;
    read_reg(8'h05, 16'h0C95, "R10 temp sample");

    // R3 sequential alternation on same word
    set_ptr(8'h06);
    rd_byte(8'h11, "R3 seq"); rd_byte(8'h31, "R3 seq");
    rd_byte(8'h11, "R3 seq"); rd_byte(8'h31, "R3 seq");
    end_txn();
    // R12 pointer write mid-read restarts at high byte
    set_ptr(8'h07); rd_byte(8'hA2, "R12 read restart");
    set_ptr(8'h00); rd_byte(8'h00, "R12 read restart"); rd_byte(8'h17, "R12 read restart");
    end_txn();

    repeat (4) @(negedge clk);
    check16("R4 all reads returned", 16'(exp_q.size()), 16'h0000);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule